// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns a one-bit sigma-delta stream into filtered multi-bit words. The input bit is sampled on a tick strobe, which in the intended system arrives once every 512 master clocks. Three integrators accumulate the accepted samples. Every N accepted samples, three comb stages difference the integrator output and produce one word, so the response is the cube of a sinc with decimation ratio N. N is a 12-bit code chosen at run time. It is limited to 19..2000 and takes effect only when the filter is restarted.

After a restart the filter holds back its words until the impulse response is fully populated. Words produced before that point are discarded and carry no data-ready strobe. A restart from the block reset waits four word periods. A restart caused by the active-low sync input, or by a channel-change request, waits three. Each delivered word is formatted at 16 or 24 bits, as unipolar straight binary or as bipolar offset binary.

Top module: `sinc3_decimator`

## Requirements
- R1: In unipolar mode (`unipolar`=1) a sample of 1 counts as 1 and a sample of 0 counts as 0. The filter value of a word completed by accepted sample n equals the sum over j of h[j]·x[n-j], where h is three length-N boxcars convolved together (length 3N-2) and samples before the last restart count as zero.
- R2: In bipolar mode (`unipolar`=0) a sample of 1 counts as +1 and a sample of 0 counts as -1. The word is the offset-binary form of the signed filter value: the top bit of the selected field is inverted, so a zero filter value reads 0x800000 at 24 bits.
- R3: With `wide_word`=1 the result is bits [33:10] of the 34-bit filter value. With `wide_word`=0 it is bits [33:18], placed in `result[15:0]` with `result[23:16]`=0.
- R4: A sample is accepted only in a cycle with `tick`=1, `sync_n`=1 and `chan_chg`=0. `mod_bit` has no effect in any other cycle.
- R5: Exactly one word is formed for every N accepted samples.
- R6: At a restart, `dec_code` is adopted as N only if it lies within 19..2000. Otherwise the previous N stays in use. If the code held during block reset is out of range, N becomes 19.
- R7: After the block reset, the first data-ready comes with the fourth word, that is after 4N accepted samples.
- R8: While `sync_n`=0 the filter state is held at zero and no data-ready occurs. After `sync_n` returns high, the first data-ready comes after 3N accepted samples.
- R9: A `chan_chg` pulse clears the filter state. The first data-ready then comes after 3N accepted samples, whatever the level of `sync_n`.
- R10: `data_rdy` is high for exactly one clock, in the cycle after the tick that completes a delivered word. `result` changes only when `data_rdy` rises and holds otherwise.
- R11: While `rst_n`=0 at a clock edge, `result` and `data_rdy` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| tick | input | 1 | Sample strobe |
| sync_n | input | 1 | Active-low filter hold and restart |
| chan_chg | input | 1 | Channel-change restart request |
| dec_code | input | 12 | Decimation ratio N |
| wide_word | input | 1 | 1: 24-bit result, 0: 16-bit result |
| unipolar | input | 1 | 1: unipolar, 0: bipolar offset binary |
| result | output | 24 | Filtered word |
| data_rdy | output | 1 | One-clock strobe for a delivered word |

## Verification
On every cycle the assertions check the following:
- the data-ready strobe is one clock wide and follows a tick;
- the result is held between strobes;
- no strobe follows a sync-low cycle;
- the integrators are empty after a clear;
- the active code stays in range;
- the decimation count stays below that code.

Only the bench scenarios can show that the word values match the triangular-cubed response for different bit patterns, that the formatting is correct in all four modes, that the settling waits of three and four words are right, and that out-of-range codes are rejected. The bench compares the design against a direct convolution model, using small ratios and both ends of the code range.

// File: rtl/sinc3_pkg.sv
// Shared constants and helpers for the sinc3 decimator.
// Assumes: callers pass a positive maximum code.
package sinc3_pkg;

    // Settling lengths in output words.
    localparam logic [2:0] SETTLE_COLD = 3'd4;
    localparam logic [2:0] SETTLE_WARM = 3'd3;

    // Accumulator width for a cubic response: 3*ceil(log2(max))+1.
    function automatic int unsigned acc_width(input int unsigned max_code);
        return 3 * $clog2(max_code) + 1;
    endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
// Sequencing for the sinc3 decimator: holds the active ratio, counts
// accepted samples, detects word boundaries and decides which words
// are delivered once the filter has settled.
// Assumes: CODE_RST lies within CODE_MIN..CODE_MAX.
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned CODE_MIN = 19,
    parameter int unsigned CODE_MAX = 2000,
    parameter int unsigned CODE_RST = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sync_n,
    input  logic              chan_chg,
    input  logic [CODE_W-1:0] dec_code,
    output logic              clr,
    output logic              take,
    output logic              dec,
    output logic              emit
);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] cnt_q;
    logic [2:0]        wcnt_q;
    logic [2:0]        settle_q;
    logic              code_ok;

    // Decode restart, acceptance, word boundary and delivery.
    always_comb begin
        code_ok = (dec_code >= CODE_W'(CODE_MIN)) && (dec_code <= CODE_W'(CODE_MAX));
        clr     = !sync_n || chan_chg;
        take    = tick && !clr;
        dec     = take && (cnt_q == code_q - CODE_W'(1));
        emit    = dec && (wcnt_q >= settle_q - 3'd1);
    end

    // Active ratio: loaded at reset or restart when the code is in range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= code_ok ? dec_code : CODE_W'(CODE_RST);
        else if (clr && code_ok)
            code_q <= dec_code;
    end

    // Sample counter within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (take)
            cnt_q <= dec ? '0 : cnt_q + CODE_W'(1);
    end

    // Words since restart, saturating at the longest settling length.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            wcnt_q <= '0;
        else if (dec && wcnt_q != SETTLE_COLD)
            wcnt_q <= wcnt_q + 3'd1;
    end

    // Settling length: long after reset, short after sync or channel change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle_q <= SETTLE_COLD;
        else if (clr)
            settle_q <= SETTLE_WARM;
    end

    a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q >= CODE_W'(CODE_MIN)) && (code_q <= CODE_W'(CODE_MAX)))
        else $error("active code out of range");

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < code_q)
        else $error("sample counter beyond ratio");

    a_r4_no_word_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !dec)
        else $error("word boundary without tick");

endmodule

// File: rtl/sinc3_integ.sv
// Three cascaded integrators with modulo arithmetic. The chain is
// combinational within a cycle, so the third stage's next value
// already includes the sample accepted in this cycle.
// Assumes: ACC_W covers the full response range; wrap is intended.
module sinc3_integ #(
    parameter int unsigned ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] x_in,
    output logic [ACC_W-1:0] acc_next
);

    logic [ACC_W-1:0] acc_q [3];
    logic [ACC_W-1:0] nxt   [3];

    for (genvar s = 0; s < 3; s++) begin : g_stage
        // Stage sum: previous stage's new value added to this stage's state.
        if (s == 0) begin : g_first
            always_comb nxt[s] = acc_q[s] + x_in;
        end else begin : g_rest
            always_comb nxt[s] = acc_q[s] + nxt[s-1];
        end

        // Stage register, cleared on reset or filter restart.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                acc_q[s] <= '0;
            else if (en)
                acc_q[s] <= nxt[s];
        end
    end

    assign acc_next = nxt[2];

    a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q[0] == '0) && (acc_q[1] == '0) && (acc_q[2] == '0))
        else $error("integrators not cleared");

endmodule

// File: rtl/sinc3_comb.sv
// Three cascaded comb (differencing) stages run at the word rate.
// The output is combinational on the word-boundary cycle.
// Assumes: en is high exactly once per N accepted samples.
module sinc3_comb #(
    parameter int unsigned ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    logic [ACC_W-1:0] dly_q [3];
    logic [ACC_W-1:0] sin   [3];
    logic [ACC_W-1:0] diff  [3];

    for (genvar s = 0; s < 3; s++) begin : g_stage
        // Stage input: filter input or previous difference.
        if (s == 0) begin : g_first
            always_comb sin[s] = din;
        end else begin : g_rest
            always_comb sin[s] = diff[s-1];
        end

        // Difference against the value held one word earlier.
        always_comb diff[s] = sin[s] - dly_q[s];

        // Word-rate delay register.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                dly_q[s] <= '0;
            else if (en)
                dly_q[s] <= sin[s];
        end
    end

    assign dout = diff[2];

endmodule

// File: rtl/sinc3_decimator.sv
// Top of the programmable sinc3 decimator: maps the modulator bit to a
// unipolar or bipolar sample, filters and decimates it, and registers the
// formatted word together with a one-clock data-ready strobe.
// Assumes: tick is a single-cycle strobe; the mode inputs are steady
// across a word.
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned CODE_MIN = 19,
    parameter int unsigned CODE_MAX = 2000,
    parameter int unsigned CODE_RST = 19,
    parameter int unsigned OUT_W    = 24,
    parameter int unsigned SHORT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_bit,
    input  logic              tick,
    input  logic              sync_n,
    input  logic              chan_chg,
    input  logic [CODE_W-1:0] dec_code,
    input  logic              wide_word,
    input  logic              unipolar,
    output logic [OUT_W-1:0]  result,
    output logic              data_rdy
);

    localparam int unsigned ACC_W = acc_width(CODE_MAX);

    logic             clr, take, dec, emit;
    logic [ACC_W-1:0] x_in, acc3, yval;
    logic [OUT_W-1:0] w_long, w_fmt;
    logic [SHORT_W-1:0] w_short;

    sinc3_ctrl #(
        .CODE_W  (CODE_W),
        .CODE_MIN(CODE_MIN),
        .CODE_MAX(CODE_MAX),
        .CODE_RST(CODE_RST)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sync_n  (sync_n),
        .chan_chg(chan_chg),
        .dec_code(dec_code),
        .clr     (clr),
        .take    (take),
        .dec     (dec),
        .emit    (emit)
    );

    // Sample mapping: 0/1 in unipolar mode, -1/+1 in bipolar mode.
    always_comb begin
        if (unipolar)
            x_in = ACC_W'(mod_bit);
        else
            x_in = mod_bit ? ACC_W'(1) : '1;
    end

    sinc3_integ #(.ACC_W(ACC_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (take),
        .x_in    (x_in),
        .acc_next(acc3)
    );

    sinc3_comb #(.ACC_W(ACC_W)) u_comb (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (dec),
        .din  (acc3),
        .dout (yval)
    );

    // Output formatting: top bits of the filter value, offset binary if bipolar.
    always_comb begin
        w_long  = yval[ACC_W-1 -: OUT_W];
        w_short = yval[ACC_W-1 -: SHORT_W];
        if (!unipolar) begin
            w_long[OUT_W-1]    = ~w_long[OUT_W-1];
            w_short[SHORT_W-1] = ~w_short[SHORT_W-1];
        end
        w_fmt = wide_word ? w_long : OUT_W'(w_short);
    end

    // Output register: load on delivered words, strobe for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            data_rdy <= 1'b0;
        end else begin
            data_rdy <= emit;
            if (emit)
                result <= w_fmt;
        end
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |=> !data_rdy)
        else $error("data-ready wider than one clock");

    a_r10_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> $past(tick))
        else $error("data-ready without a preceding tick");

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rdy |-> $stable(result))
        else $error("result changed without data-ready");

    a_r8_quiet_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> !data_rdy)
        else $error("data-ready after sync-low cycle");

endmodule

// File: tb/test_sinc3_decimator.sv
module test_sinc3_decimator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_bit = 1'b0;
    logic        tick = 1'b0;
    logic        sync_n = 1'b1;
    logic        chan_chg = 1'b0;
    logic [11:0] dec_code = 12'd25;
    logic        wide_word = 1'b1;
    logic        unipolar = 1'b1;
    logic [23:0] result;
    logic        data_rdy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    longint xs [0:8191];
    longint h  [0:5999];
    int nx, nb, nh, settle, delivered;
    logic [23:0] last_word;
    logic [15:0] lfsr = 16'hACE1;

    sinc3_decimator i_sinc3_decimator (
        .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .tick(tick),
        .sync_n(sync_n), .chan_chg(chan_chg), .dec_code(dec_code),
        .wide_word(wide_word), .unipolar(unipolar),
        .result(result), .data_rdy(data_rdy)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Response of three convolved length-n boxcars.
    task automatic build_h(input int n);
        if (n == nh) return;
        for (int j = 0; j <= 3*n-3; j++) begin
            longint s = 0;
            int lo = (j - n + 1 > 0) ? j - n + 1 : 0;
            int hi = (j < 2*n-2) ? j : 2*n-2;
            for (int i = lo; i <= hi; i++)
                s += ((i + 1) < (2*n-1-i)) ? (i + 1) : (2*n-1-i);
            h[j] = s;
        end
        nh = n;
    endtask

    function automatic logic [23:0] expect_word();
        longint y = 0;
        logic [33:0] v;
        logic [23:0] w;
        logic [15:0] s;
        for (int j = 0; j <= 3*nb-3; j++)
            if (nx - 1 - j >= 0) y += h[j] * xs[nx-1-j];
        v = y[33:0];
        w = v[33:10];
        s = v[33:18];
        if (!unipolar) begin
            w[23] = ~w[23];
            s[15] = ~s[15];
        end
        return wide_word ? w : {8'h00, s};
    endfunction

    function automatic bit pat_bit(input int pat, input int i);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return i[0];
            3: return lfsr[0];
            default: return (i >= 45);
        endcase
    endfunction

    // Check the outputs after an edge with no accepted sample.
    task automatic idle_check(input string req);
        check(req, {31'd0, data_rdy}, 32'd0);
        check("R10", {8'd0, result}, {8'd0, last_word});
    endtask

    // Feed samples (with optional idle gaps), checking each edge.
    task automatic feed(input int count, input int pat, input int gap);
        for (int k = 0; k < count; k++) begin
            for (int g = 0; g < gap; g++) begin
                mod_bit = ~mod_bit;
                tick = 1'b0;
                @(posedge clk); @(negedge clk);
                idle_check("R4");
            end
            mod_bit = pat_bit(pat, k);
            tick = 1'b1;
            xs[nx] = unipolar ? longint'(mod_bit) : (mod_bit ? 64'sd1 : -64'sd1);
            nx++;
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            @(posedge clk); @(negedge clk);
            tick = 1'b0;
            if (nx % nb == 0 && nx / nb >= settle) begin
                check("R5", {31'd0, data_rdy}, 32'd1);
                if (delivered == 0)
                    check(settle == 4 ? "R7" : "R8/R9 first word", nx, settle * nb);
                check(unipolar ? "R1" : "R2", {8'd0, result}, {8'd0, expect_word()});
                if (!wide_word) check("R3", {8'd0, result[23:16]}, 32'd0);
                last_word = result;
                delivered++;
            end else begin
                idle_check("R5");
            end
        end
    endtask

    task automatic restart_common(input logic [11:0] c);
        if (c >= 19 && c <= 2000) nb = c;
        build_h(nb);
        nx = 0;
        settle = 3;
        delivered = 0;
    endtask

    // Hold sync low for some cycles while ticks and bits toggle.
    task automatic do_sync(input logic [11:0] c, input int hold);
        dec_code = c;
        sync_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            tick = 1'b1;
            mod_bit = ~mod_bit;
            @(posedge clk); @(negedge clk);
            idle_check("R8");
        end
        tick = 1'b0;
        sync_n = 1'b1;
        restart_common(c);
    endtask

    task automatic do_chg(input logic [11:0] c);
        dec_code = c;
        chan_chg = 1'b1;
        tick = 1'b1;
        mod_bit = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_check("R9");
        chan_chg = 1'b0;
        tick = 1'b0;
        restart_common(c);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        nh = 0;
        last_word = '0;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", {8'd0, result}, 32'd0);
        check("R11", {31'd0, data_rdy}, 32'd0);
        rst_n = 1'b1;
        nb = 25; build_h(25); nx = 0; settle = 4; delivered = 0;
        // R7: cold start, all ones, unipolar 24-bit
        feed(150, 1, 0);
        // R1: pseudo-random stream, sync restart
        do_sync(12'd20, 3);
        feed(160, 3, 0);
        // R2: bipolar, random then alternating then step
        unipolar = 1'b0;
        do_sync(12'd24, 2);
        feed(168, 3, 0);
        do_sync(12'd22, 2);
        feed(132, 2, 0);
        do_sync(12'd30, 2);
        feed(180, 4, 0);
        // R3: 16-bit word, bipolar and unipolar
        wide_word = 1'b0;
        feed(60, 3, 0);
        unipolar = 1'b1;
        do_sync(12'd21, 2);
        feed(126, 3, 0);
        // R3/R6: largest ratio, all ones, 16 and 24 bits
        do_sync(12'd2000, 2);
        feed(6000, 1, 0);
        wide_word = 1'b1;
        feed(2000, 1, 0);
        // R6: rejected codes keep the previous ratio
        do_sync(12'd22, 2);
        feed(70, 3, 0);
        do_sync(12'd18, 2);
        feed(90, 3, 0);
        do_sync(12'd2001, 2);
        feed(90, 3, 0);
        do_sync(12'd19, 2);
        feed(80, 3, 0);
        // R9: channel change with sync high, and during sync low
        feed(10, 3, 0);
        do_chg(12'd23);
        feed(100, 3, 0);
        sync_n = 1'b0;
        do_chg(12'd26);
        sync_n = 1'b1;
        restart_common(12'd26);
        feed(110, 3, 0);
        // R4: gaps between ticks with bit toggling
        do_sync(12'd20, 2);
        feed(80, 3, 2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule